// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This unit sits beside a processor's exception logic and decides, on every clock, whether the interrupt level presented on its pending-level input may be taken. It takes the level only when that level is above the interrupt level in the status word, lies within the configured number of levels, and has at least one interrupt line that is both raised and enabled among the lines the per-level mask table assigns to it. When it takes a level, it saves the current PC and status word, computes the new status word and the redirect address, and emits a one-cycle pulse.

Levels above 1 are dispatched straight to their own vector. Each such level has its own saved-PC and saved-status registers. Level 1 is turned into an ordinary exception instead. It becomes a double exception when the status word is already in exception mode, a user exception when user mode is set, and a kernel exception otherwise. In every level-1 case the cause register is loaded with a fixed interrupt cause code.

Every vector address is a fixed offset from a base. When vector relocation is enabled, that base is the vector-base input, which is equivalent to subtracting the default base from the default vector and adding the vector-base input.

Top module: `irq_dispatch`

## Requirements
- R1: A level L is accepted only when L is strictly greater than status bits [3:0], L is at most NLEVELS (6), and the AND of L's mask (level_mask bits [(L-1)*32 +: 32]), int_set and int_enable is nonzero. Otherwise nothing is taken.
- R2: Each accepted dispatch raises `taken` for exactly the cycle after the deciding clock edge. A rejected cycle leaves status_out, new_pc, exc_class, exc_cause and all saved registers unchanged.
- R3: For L > 1, pc_in is saved in L's saved-PC slot (epc_flat[(L-1)*32 +: 32]) and status_in is saved in L's saved-status slot (eps_flat[(L-2)*32 +: 32]).
- R4: For L > 1, status_out equals status_in with bits [3:0] replaced by L and bit 4 (exception mode) set.
- R5: With relocation enabled, a level L > 1 redirects new_pc to vecbase_in + 0x180 + (L-2)*0x40.
- R6: A level-1 dispatch loads exc_cause with 4. A dispatch of a level above 1 leaves exc_cause unchanged.
- R7: Level 1 with status bit 4 set gives exc_class 4 (double) and saves pc_in in depc_out, leaving the level-1 saved-PC slot unchanged.
- R8: Level 1 with status bit 4 clear saves pc_in in the level-1 slot. It gives exc_class 3 (user) when status bit 5 is set and 2 (kernel) otherwise. A level above 1 gives exc_class 1.
- R9: After a level-1 dispatch, status_out equals status_in with bit 4 set. All other bits, including [3:0], are kept.
- R10: Level-1 redirects go to vecbase_in + 0x300 (kernel), + 0x340 (user) or + 0x3C0 (double).
- R11: After reset, taken, status_out, new_pc, exc_class, exc_cause and all saved registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pend_level | input | 4 | Highest pending interrupt level |
| int_set | input | 32 | Raised interrupt lines |
| int_enable | input | 32 | Enabled interrupt lines |
| level_mask | input | 192 | Per-level line masks, level L at [(L-1)*32 +: 32] |
| status_in | input | 32 | Current status word |
| pc_in | input | 32 | Current PC |
| vecbase_in | input | 32 | Vector-base register |
| taken | output | 1 | One-cycle dispatch pulse |
| status_out | output | 32 | Status word produced by the last dispatch |
| new_pc | output | 32 | Redirect address of the last dispatch |
| exc_class | output | 3 | 1 level, 2 kernel, 3 user, 4 double |
| exc_cause | output | 8 | Exception cause register |
| epc_flat | output | 192 | Saved PCs for levels 1..6 |
| eps_flat | output | 160 | Saved status words for levels 2..6 |
| depc_out | output | 32 | Double-exception saved PC |

## Verification
A wrong acceptance decision appears on `taken` one cycle after the edge that evaluated the inputs. A wrong save-slot choice is visible at once in the flat saved-register outputs, either as a slot that changed when it should not have or as a slot that kept its old value. A misrouted level-1 decision appears in the same cycle on exc_class and new_pc, and a slot that was wrongly overwritten stays visible until the next dispatch. This holds because every output is registered and is held between dispatches, so the bench can read any corruption after the stimulus and before the next dispatch.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
   typedef enum logic [2:0] {
      CLS_NONE   = 3'd0,
      CLS_LEVEL  = 3'd1,
      CLS_KERNEL = 3'd2,
      CLS_USER   = 3'd3,
      CLS_DOUBLE = 3'd4
   } exc_class_e;
endpackage

// File: rtl/irq_accept.sv
module irq_accept #(
   parameter int NLEVELS = 6,
   parameter int NLINES  = 32,
   parameter int LVLW    = 4
) (
   input  logic [LVLW-1:0]           pend,
   input  logic [LVLW-1:0]           cur_lvl,
   input  logic [NLINES-1:0]         lines_set,
   input  logic [NLINES-1:0]         lines_en,
   input  logic [NLEVELS*NLINES-1:0] mask,
   output logic                      accept
);
   localparam int HITW = NLEVELS + 1;

   logic [HITW-1:0] hit;
   logic            hit_sel;
   logic            in_range;
   logic            above;

   assign hit[0] = 1'b0;
   for (genvar g = 1; g <= NLEVELS; g++) begin : g_lvl
      assign hit[g] = |(mask[(g-1)*NLINES +: NLINES] & lines_set & lines_en);
   end

   always_comb begin
      hit_sel = 1'b0;
      for (int i = 0; i < HITW; i++) begin
         if (int'(pend) == i) hit_sel = hit[i];
      end
   end

   assign in_range = int'(pend) <= NLEVELS;
   assign above    = pend > cur_lvl;
   assign accept   = above && in_range && hit_sel;
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
   import irq_dispatch_pkg::*;
#(
   parameter int              XLEN           = 32,
   parameter int              LVLW           = 4,
   parameter bit              RELOC_VEC      = 1'b1,
   parameter logic [XLEN-1:0] DEF_VECBASE    = 'h2000_0000,
   parameter logic [XLEN-1:0] LVL_VEC_OFS    = 'h180,
   parameter logic [XLEN-1:0] LVL_VEC_STRIDE = 'h40,
   parameter logic [XLEN-1:0] KERN_OFS       = 'h300,
   parameter logic [XLEN-1:0] USER_OFS       = 'h340,
   parameter logic [XLEN-1:0] DBL_OFS        = 'h3C0
) (
   input  logic [LVLW-1:0] lvl,
   input  exc_class_e      cls,
   input  logic [XLEN-1:0] vecbase,
   output logic [XLEN-1:0] vec
);
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offs;
   logic [XLEN-1:0] lvl_w;

   if (RELOC_VEC) begin : g_reloc
      assign base = vecbase;
   end else begin : g_fixed
      assign base = DEF_VECBASE;
   end

   assign lvl_w = XLEN'(lvl);

   always_comb begin
      unique case (cls)
         CLS_KERNEL: offs = KERN_OFS;
         CLS_USER:   offs = USER_OFS;
         CLS_DOUBLE: offs = DBL_OFS;
         CLS_LEVEL:  offs = LVL_VEC_OFS + (lvl_w - XLEN'(2)) * LVL_VEC_STRIDE;
         default:    offs = '0;
      endcase
   end

   assign vec = base + offs;
endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank #(
   parameter int XLEN     = 32,
   parameter int NLEVELS  = 6,
   parameter bit HAS_DEPC = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NLEVELS-1:0]          epc_we,
   input  logic [NLEVELS-2:0]          eps_we,
   input  logic                        depc_we,
   input  logic [XLEN-1:0]             pc_d,
   input  logic [XLEN-1:0]             ps_d,
   output logic [NLEVELS*XLEN-1:0]     epc_q,
   output logic [(NLEVELS-1)*XLEN-1:0] eps_q,
   output logic [XLEN-1:0]             depc_q
);
   for (genvar g = 0; g < NLEVELS; g++) begin : g_epc
      logic [XLEN-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         r <= '0;
         else if (epc_we[g]) r <= pc_d;
      end
      assign epc_q[g*XLEN +: XLEN] = r;
   end

   for (genvar g = 0; g < NLEVELS-1; g++) begin : g_eps
      logic [XLEN-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         r <= '0;
         else if (eps_we[g]) r <= ps_d;
      end
      assign eps_q[g*XLEN +: XLEN] = r;
   end

   if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       r <= '0;
         else if (depc_we) r <= pc_d;
      end
      assign depc_q = r;
   end else begin : g_no_depc
      assign depc_q = '0;
   end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irq_dispatch_pkg::*;
#(
   parameter int              XLEN           = 32,
   parameter int              NLINES         = 32,
   parameter int              NLEVELS        = 6,
   parameter int              LVLW           = 4,
   parameter int              CAUSEW         = 8,
   parameter logic [CAUSEW-1:0] L1_CAUSE     = 'd4,
   parameter bit              HAS_DEPC       = 1'b1,
   parameter bit              RELOC_VEC      = 1'b1,
   parameter logic [XLEN-1:0] DEF_VECBASE    = 'h2000_0000,
   parameter logic [XLEN-1:0] LVL_VEC_OFS    = 'h180,
   parameter logic [XLEN-1:0] LVL_VEC_STRIDE = 'h40,
   parameter logic [XLEN-1:0] KERN_OFS       = 'h300,
   parameter logic [XLEN-1:0] USER_OFS       = 'h340,
   parameter logic [XLEN-1:0] DBL_OFS        = 'h3C0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LVLW-1:0]             pend_level,
   input  logic [NLINES-1:0]           int_set,
   input  logic [NLINES-1:0]           int_enable,
   input  logic [NLEVELS*NLINES-1:0]   level_mask,
   input  logic [XLEN-1:0]             status_in,
   input  logic [XLEN-1:0]             pc_in,
   input  logic [XLEN-1:0]             vecbase_in,
   output logic                        taken,
   output logic [XLEN-1:0]             status_out,
   output logic [XLEN-1:0]             new_pc,
   output logic [2:0]                  exc_class,
   output logic [CAUSEW-1:0]           exc_cause,
   output logic [NLEVELS*XLEN-1:0]     epc_flat,
   output logic [(NLEVELS-1)*XLEN-1:0] eps_flat,
   output logic [XLEN-1:0]             depc_out
);
   localparam int EXCM_BIT = LVLW;
   localparam int UM_BIT   = LVLW + 1;

   if (NLEVELS < 2 || NLEVELS >= (1 << LVLW)) begin : g_chk_lvl
      $error("NLEVELS must fit the level field and be at least 2");
   end
   if (XLEN <= UM_BIT) begin : g_chk_xlen
      $error("status word too narrow for mode bits");
   end

   logic            accept;
   logic            is_l1;
   logic            is_hi;
   logic            excm;
   logic            umode;
   exc_class_e      cls_n;
   logic [XLEN-1:0] ps_n;
   logic [XLEN-1:0] vec;
   logic [NLEVELS-1:0] epc_we;
   logic [NLEVELS-2:0] eps_we;
   logic            depc_we;

   logic            taken_q;
   logic [XLEN-1:0] ps_q;
   logic [XLEN-1:0] pc_q;
   exc_class_e      cls_q;
   logic [CAUSEW-1:0] cause_q;

   irq_accept #(
      .NLEVELS(NLEVELS), .NLINES(NLINES), .LVLW(LVLW)
   ) u_accept (
      .pend      (pend_level),
      .cur_lvl   (status_in[LVLW-1:0]),
      .lines_set (int_set),
      .lines_en  (int_enable),
      .mask      (level_mask),
      .accept    (accept)
   );

   assign excm  = status_in[EXCM_BIT];
   assign umode = status_in[UM_BIT];
   assign is_l1 = accept && (pend_level == LVLW'(1));
   assign is_hi = accept && (pend_level != LVLW'(1));

   always_comb begin
      if (is_hi)            cls_n = CLS_LEVEL;
      else if (!is_l1)      cls_n = CLS_NONE;
      else if (excm)        cls_n = CLS_DOUBLE;
      else if (umode)       cls_n = CLS_USER;
      else                  cls_n = CLS_KERNEL;
   end

   always_comb begin
      ps_n = status_in;
      ps_n[EXCM_BIT] = 1'b1;
      if (is_hi) ps_n[LVLW-1:0] = pend_level;
   end

   irq_vector_gen #(
      .XLEN(XLEN), .LVLW(LVLW), .RELOC_VEC(RELOC_VEC),
      .DEF_VECBASE(DEF_VECBASE), .LVL_VEC_OFS(LVL_VEC_OFS),
      .LVL_VEC_STRIDE(LVL_VEC_STRIDE), .KERN_OFS(KERN_OFS),
      .USER_OFS(USER_OFS), .DBL_OFS(DBL_OFS)
   ) u_vec (
      .lvl     (pend_level),
      .cls     (cls_n),
      .vecbase (vecbase_in),
      .vec     (vec)
   );

   assign epc_we[0] = is_l1 && (!excm || !HAS_DEPC);
   for (genvar g = 1; g < NLEVELS; g++) begin : g_we
      assign epc_we[g]   = is_hi && (pend_level == LVLW'(g + 1));
      assign eps_we[g-1] = is_hi && (pend_level == LVLW'(g + 1));
   end
   assign depc_we = is_l1 && excm && HAS_DEPC;

   irq_save_bank #(
      .XLEN(XLEN), .NLEVELS(NLEVELS), .HAS_DEPC(HAS_DEPC)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .epc_we  (epc_we),
      .eps_we  (eps_we),
      .depc_we (depc_we),
      .pc_d    (pc_in),
      .ps_d    (status_in),
      .epc_q   (epc_flat),
      .eps_q   (eps_flat),
      .depc_q  (depc_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q <= 1'b0;
         ps_q    <= '0;
         pc_q    <= '0;
         cls_q   <= CLS_NONE;
         cause_q <= '0;
      end else begin
         taken_q <= accept;
         if (accept) begin
            ps_q  <= ps_n;
            pc_q  <= vec;
            cls_q <= cls_n;
         end
         if (is_l1) cause_q <= L1_CAUSE;
      end
   end

   assign taken      = taken_q;
   assign status_out = ps_q;
   assign new_pc     = pc_q;
   assign exc_class  = cls_q;
   assign exc_cause  = cause_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
   parameter int XLEN   = 32,
   parameter int LVLW   = 4,
   parameter int CAUSEW = 8,
   parameter logic [CAUSEW-1:0] L1_CAUSE = 'd4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LVLW-1:0]   pend_level,
   input logic [XLEN-1:0]   status_in,
   input logic              taken,
   input logic [XLEN-1:0]   status_out,
   input logic [XLEN-1:0]   new_pc,
   input logic [2:0]        exc_class,
   input logic [CAUSEW-1:0] exc_cause
);
   AST_NO_TAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_level <= status_in[LVLW-1:0]) |=> !taken); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |-> ($stable(status_out) && $stable(new_pc) && $stable(exc_class))); // R2
   AST_LVL_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && exc_class == 3'd1) |-> (status_out[LVLW-1:0] == $past(pend_level))); // R4
   AST_EXCM_SET: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> status_out[LVLW]); // R9
   AST_L1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && exc_class != 3'd1) |-> (exc_cause == L1_CAUSE)); // R6
   AST_CLASS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> (exc_class != 3'd0 && exc_class <= 3'd4)); // R8
endmodule

bind irq_dispatch irq_dispatch_chk #(
   .XLEN(XLEN), .LVLW(LVLW), .CAUSEW(CAUSEW), .L1_CAUSE(L1_CAUSE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pend_level (pend_level),
   .status_in  (status_in),
   .taken      (taken),
   .status_out (status_out),
   .new_pc     (new_pc),
   .exc_class  (exc_class),
   .exc_cause  (exc_cause)
);

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   pend_level = '0;
   logic [31:0]  int_set = '0;
   logic [31:0]  int_enable = '0;
   logic [191:0] level_mask;
   logic [31:0]  status_in = '0;
   logic [31:0]  pc_in = '0;
   logic [31:0]  vecbase_in = '0;
   logic         taken;
   logic [31:0]  status_out;
   logic [31:0]  new_pc;
   logic [2:0]   exc_class;
   logic [7:0]   exc_cause;
   logic [191:0] epc_flat;
   logic [159:0] eps_flat;
   logic [31:0]  depc_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_dispatch uut (
      .clk(clk), .rst_n(rst_n), .pend_level(pend_level), .int_set(int_set),
      .int_enable(int_enable), .level_mask(level_mask), .status_in(status_in),
      .pc_in(pc_in), .vecbase_in(vecbase_in), .taken(taken),
      .status_out(status_out), .new_pc(new_pc), .exc_class(exc_class),
      .exc_cause(exc_cause), .epc_flat(epc_flat), .eps_flat(eps_flat),
      .depc_out(depc_out)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] epc(int l);
      return epc_flat[(l-1)*32 +: 32];
   endfunction
   function automatic logic [31:0] eps(int l);
      return eps_flat[(l-2)*32 +: 32];
   endfunction

   // drive one cycle of stimulus, leave outputs ready at the next negedge
   task automatic present(logic [3:0] lvl, logic [31:0] s, logic [31:0] e,
                          logic [31:0] ps, logic [31:0] pc, logic [31:0] vb);
      pend_level = lvl; int_set = s; int_enable = e;
      status_in = ps; pc_in = pc; vecbase_in = vb;
      @(negedge clk);
      pend_level = '0;
   endtask

   task automatic t_reset();
      chk("R11 taken", {31'd0, taken}, 32'd0);
      chk("R11 status", status_out, 32'd0);
      chk("R11 pc", new_pc, 32'd0);
      chk("R11 class", {29'd0, exc_class}, 32'd0);
      chk("R11 cause", {24'd0, exc_cause}, 32'd0);
      chk("R11 epc1", epc(1), 32'd0);
      chk("R11 eps6", eps(6), 32'd0);
      chk("R11 depc", depc_out, 32'd0);
   endtask

   task automatic t_level3();
      present(4'd3, 32'h4, 32'h4, 32'hABCD_0041, 32'h0000_5550, 32'h8000_1000);
      chk("R2 taken", {31'd0, taken}, 32'd1);
      chk("R3 epc3", epc(3), 32'h0000_5550);
      chk("R3 eps3", eps(3), 32'hABCD_0041);
      chk("R3 epc2 untouched", epc(2), 32'd0);
      chk("R4 status", status_out, 32'hABCD_0053);
      chk("R5 vector", new_pc, 32'h8000_11C0);
      chk("R8 class level", {29'd0, exc_class}, 32'd1);
      chk("R6 cause kept", {24'd0, exc_cause}, 32'd0);
      @(negedge clk);
      chk("R2 pulse ends", {31'd0, taken}, 32'd0);
   endtask

   task automatic t_rejects();
      present(4'd3, 32'h4, 32'h0, 32'h0, 32'h1111, 32'h0);
      chk("R1 enable clear", {31'd0, taken}, 32'd0);
      present(4'd3, 32'h0, 32'h4, 32'h0, 32'h1111, 32'h0);
      chk("R1 set clear", {31'd0, taken}, 32'd0);
      present(4'd3, 32'h2, 32'h2, 32'h0, 32'h1111, 32'h0);
      chk("R1 other level line", {31'd0, taken}, 32'd0);
      present(4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h1111, 32'h0);
      chk("R1 above NLEVELS", {31'd0, taken}, 32'd0);
      present(4'd2, 32'h2, 32'h2, 32'h2, 32'h1111, 32'h0);
      chk("R1 equal level", {31'd0, taken}, 32'd0);
      chk("R2 status held", status_out, 32'hABCD_0053);
      chk("R2 pc held", new_pc, 32'h8000_11C0);
      chk("R2 epc2 held", epc(2), 32'd0);
      chk("R2 eps2 held", eps(2), 32'd0);
   endtask

   task automatic t_level6();
      present(4'd6, 32'h0000_2000, 32'h0000_2000, 32'h0000_0025, 32'h0000_7770, 32'h0004_0000);
      chk("R2 taken l6", {31'd0, taken}, 32'd1);
      chk("R3 epc6", epc(6), 32'h0000_7770);
      chk("R3 eps6", eps(6), 32'h0000_0025);
      chk("R4 status l6", status_out, 32'h0000_0036);
      chk("R5 vector l6", new_pc, 32'h0004_0280);
      chk("R3 epc3 kept", epc(3), 32'h0000_5550);
   endtask

   task automatic t_kernel();
      present(4'd1, 32'h1, 32'h1, 32'h0000_0000, 32'h0000_1000, 32'h8000_1000);
      chk("R8 class kernel", {29'd0, exc_class}, 32'd2);
      chk("R8 epc1", epc(1), 32'h0000_1000);
      chk("R6 cause", {24'd0, exc_cause}, 32'd4);
      chk("R9 status", status_out, 32'h0000_0010);
      chk("R10 kernel vector", new_pc, 32'h8000_1300);
   endtask

   task automatic t_user();
      present(4'd1, 32'h100, 32'h100, 32'hF000_0020, 32'h0000_2000, 32'h8000_1000);
      chk("R8 class user", {29'd0, exc_class}, 32'd3);
      chk("R8 epc1 user", epc(1), 32'h0000_2000);
      chk("R9 status user", status_out, 32'hF000_0030);
      chk("R10 user vector", new_pc, 32'h8000_1340);
   endtask

   task automatic t_double();
      present(4'd1, 32'h1, 32'h1, 32'h0000_0010, 32'h0000_3000, 32'h8000_1000);
      chk("R7 class double", {29'd0, exc_class}, 32'd4);
      chk("R7 depc", depc_out, 32'h0000_3000);
      chk("R7 epc1 kept", epc(1), 32'h0000_2000);
      chk("R9 status double", status_out, 32'h0000_0010);
      chk("R10 double vector", new_pc, 32'h8000_13C0);
      present(4'd1, 32'h1, 32'h1, 32'h0000_0011, 32'h0000_4000, 32'h8000_1000);
      chk("R1 l1 masked by level", {31'd0, taken}, 32'd0);
      chk("R2 depc held", depc_out, 32'h0000_3000);
   endtask

   initial begin
      level_mask = '0;
      for (int l = 1; l <= 6; l++) begin
         level_mask[(l-1)*32 + (l-1)] = 1'b1;
         level_mask[(l-1)*32 + l + 7] = 1'b1;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_level3();
      t_rejects();
      t_level6();
      t_kernel();
      t_user();
      t_double();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule